// File: doc/BRIEF.md
# Receive Frame Queue with Per-Frame Error Status

This block sits between a serial frame receiver and the register-read side of a host interface. Each time the receiver finishes a frame it presents the eight data bits, an optional ninth data bit, and the frame (stop-bit) and parity error results on a one-cycle valid strobe. The frame first lands in a single holding stage, which stands in for the receive shift register. From there it drops into a two-entry FIFO. The host sees the head entry's data, ninth bit and error flags as plain outputs, and it pops the head with a read strobe.

Error flags travel through the queue with their own frame. The host therefore always sees the status that belongs to the character it is about to read. An overrun is noticed when a new start bit arrives while the FIFO is full and the holding stage still holds an unmoved frame. The held frame is then lost, and the overrun mark is attached to the next frame that enters the FIFO. Dropping the receiver enable empties everything. A level interrupt request follows the data-available flag while the interrupt enable is set.

Top module: `rxq_buffer`

## Requirements
- R1: After synchronous reset, `data_avail` and `irq` are 0 and all head outputs (`rd_data`, `rd_bit9`, `rd_frm_err`, `rd_ovr`, `rd_par_err`) are 0.
- R2: A frame strobed in with `wr_valid` while the FIFO has room is visible at the head two clock edges later, with its data, ninth bit, frame error and parity error unchanged, and `data_avail` is then 1.
- R3: The FIFO holds two frames and the holding stage a third. Frames leave in arrival order.
- R4: A `rd_pop` on a non-empty FIFO removes the head, so the next entry's data and flags appear after that edge. A `rd_pop` on an empty FIFO has no effect.
- R5: When the FIFO is full and a frame waits in the holding stage, a pop moves the waiting frame into the FIFO at the same edge. The FIFO stays full.
- R6: A `start_det` pulse while the FIFO is full, a frame is held and no pop is taking place discards the held frame. The next frame to enter the FIFO then carries `rd_ovr` = 1.
- R7: The overrun mark is cleared once it has been attached to a frame moved into the FIFO, so later frames carry `rd_ovr` = 0.
- R8: With `rx_en` = 0 the FIFO, the holding stage and the pending overrun mark are emptied at the next edge. `data_avail` reads 0 and `wr_valid` is ignored.
- R9: `irq` is 1 exactly while `data_avail` is 1 and `irq_en` is 1. It stays high until the FIFO is drained. Error flags never raise it on their own.
- R10: While the FIFO is empty, all head outputs read 0.
- R11: A `start_det` pulse is harmless unless the FIFO is full and a frame is held: no frame is lost and no overrun mark is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the queue |
| irq_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | One-cycle strobe: a completed frame is present |
| wr_data | input | 8 | Low eight data bits of the completed frame |
| wr_bit9 | input | 1 | Ninth data bit of the completed frame |
| wr_frm_err | input | 1 | Stop bit was read as 0 |
| wr_par_err | input | 1 | Parity check failed |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| rd_pop | input | 1 | Read strobe; pops the head entry |
| rd_data | output | 8 | Head entry data bits |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_frm_err | output | 1 | Head entry frame error |
| rd_ovr | output | 1 | Head entry overrun mark |
| rd_par_err | output | 1 | Head entry parity error |
| data_avail | output | 1 | At least one unread frame is queued |
| irq | output | 1 | Level interrupt request |

## Verification
The bench fills the queue to three frames and pops with a frame waiting in the holding stage. A design that refused the simultaneous move and pop would leave a stale head or lose the waiting frame. It raises a start bit against a full queue, then against a queue with an empty holding stage. A design that attached the overrun mark to the wrong frame, or set it in the harmless case, would show `rd_ovr` on the wrong read. It also pops an empty queue and disables the receiver while frames are queued. A design whose count went negative, or that kept data across a disable, would then report stale or phantom frames.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              frm_err;
        logic              ovr;
        logic              par_err;
    } rxq_entry_t;

    localparam int ENTRY_W = $bits(rxq_entry_t);

    function automatic rxq_entry_t rxq_make(
        input logic [DATA_W-1:0] d,
        input logic              b9,
        input logic              fe,
        input logic              ov,
        input logic              pe
    );
        rxq_entry_t e;
        e.data    = d;
        e.bit9    = b9;
        e.frm_err = fe;
        e.ovr     = ov;
        e.par_err = pe;
        return e;
    endfunction

endpackage

// File: rtl/rxq_ovr.sv
module rxq_ovr (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic start_det,
    input  logic fifo_full,
    input  logic hold_vld,
    input  logic take,
    output logic ovr_hit,
    output logic ovr_pend
);

    assign ovr_hit = start_det && fifo_full && hold_vld && !take;

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            ovr_pend <= 1'b0;
        end else if (ovr_hit) begin
            ovr_pend <= 1'b1;
        end else if (take) begin
            ovr_pend <= 1'b0;
        end
    end

    AST_OVR_MARKED: assert property (@(posedge clk) disable iff (rst)
        (ovr_hit && rx_en) |=> ovr_pend) else $error("overrun not marked"); // R6

    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (take && !ovr_hit) |=> !ovr_pend) else $error("overrun not cleared"); // R7

endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       wr_valid,
    input  rxq_entry_t wr_entry,
    input  logic       take,
    input  logic       drop,
    input  logic       ovr_pend,
    output logic       hold_vld,
    output rxq_entry_t hold_entry
);

    rxq_entry_t held_q;

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            hold_vld <= 1'b0;
            held_q   <= '0;
        end else if (wr_valid) begin
            hold_vld <= 1'b1;
            held_q   <= wr_entry;
        end else if (take || drop) begin
            hold_vld <= 1'b0;
        end
    end

    always_comb begin
        hold_entry     = held_q;
        hold_entry.ovr = ovr_pend;
    end

    AST_DROP_LOSES: assert property (@(posedge clk) disable iff (rst)
        (drop && !wr_valid) |=> !hold_vld) else $error("held frame kept after overrun"); // R6

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !hold_vld) else $error("hold stage not flushed"); // R8

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       push,
    input  rxq_entry_t push_entry,
    input  logic       pop,
    output rxq_entry_t head,
    output logic       empty,
    output logic       full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rxq_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = slots[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (push_ok && !flush && (wptr == PTR_W'(i))) begin
                slots[i] <= push_entry;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(push && full && !pop)) else $error("push into full queue"); // R3

    AST_SWAP_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full && !flush) |=> full) else $error("full lost on swap"); // R5

    AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> empty) else $error("pop on empty moved state"); // R4

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              irq_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              wr_frm_err,
    input  logic              wr_par_err,
    input  logic              start_det,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_frm_err,
    output logic              rd_ovr,
    output logic              rd_par_err,
    output logic              data_avail,
    output logic              irq
);

    rxq_entry_t wr_entry, hold_entry, head, shown;
    logic       hold_vld, fifo_empty, fifo_full;
    logic       pop_eff, take, ovr_hit, ovr_pend;

    assign wr_entry = rxq_make(wr_data, wr_bit9, wr_frm_err, 1'b0, wr_par_err);
    assign pop_eff  = rd_pop && !fifo_empty && rx_en;
    assign take     = rx_en && hold_vld && (!fifo_full || pop_eff);

    rxq_ovr u_ovr (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .start_det (start_det),
        .fifo_full (fifo_full),
        .hold_vld  (hold_vld),
        .take      (take),
        .ovr_hit   (ovr_hit),
        .ovr_pend  (ovr_pend)
    );

    rxq_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .wr_valid   (wr_valid),
        .wr_entry   (wr_entry),
        .take       (take),
        .drop       (ovr_hit),
        .ovr_pend   (ovr_pend),
        .hold_vld   (hold_vld),
        .hold_entry (hold_entry)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (!rx_en),
        .push       (take),
        .push_entry (hold_entry),
        .pop        (pop_eff),
        .head       (head),
        .empty      (fifo_empty),
        .full       (fifo_full)
    );

    assign shown      = fifo_empty ? '0 : head;
    assign rd_data    = shown.data;
    assign rd_bit9    = shown.bit9;
    assign rd_frm_err = shown.frm_err;
    assign rd_ovr     = shown.ovr;
    assign rd_par_err = shown.par_err;
    assign data_avail = !fifo_empty;
    assign irq        = data_avail && irq_en;

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !data_avail) else $error("queue survived disable"); // R8

    AST_AVAIL_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(data_avail) |-> $past(hold_vld)) else $error("data appeared from nowhere"); // R2

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !data_avail |-> (rd_data == '0 && !rd_ovr && !rd_frm_err && !rd_par_err && !rd_bit9))
        else $error("empty head not zero"); // R10

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        irq |-> (data_avail && irq_en)) else $error("irq without data"); // R9

endmodule

// File: tb/rxq_buffer_tb.sv
module rxq_buffer_tb;
    import rxq_pkg::*;

    logic clk = 1'b0;
    logic rst, rx_en, irq_en, wr_valid, wr_bit9, wr_frm_err, wr_par_err, start_det, rd_pop;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic rd_bit9, rd_frm_err, rd_ovr, rd_par_err, data_avail, irq;

    int total = 0;
    int bad = 0;
    rxq_entry_t sb_q[$];

    always #4 clk = ~clk;

    rxq_buffer u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .irq_en(irq_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
        .wr_frm_err(wr_frm_err), .wr_par_err(wr_par_err),
        .start_det(start_det), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_frm_err(rd_frm_err),
        .rd_ovr(rd_ovr), .rd_par_err(rd_par_err),
        .data_avail(data_avail), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: strobe one frame, then allow the move cycle; expected item queued when kept
    task automatic send(input logic [7:0] d, input logic b9, input logic fe, input logic pe,
                        input logic exp_ovr, input bit keep);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_bit9 = b9; wr_frm_err = fe; wr_par_err = pe;
        @(negedge clk);
        wr_valid = 1'b0;
        @(negedge clk);
        if (keep) sb_q.push_back(rxq_make(d, b9, fe, exp_ovr, pe));
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    // monitor: compare head against scoreboard, then pop it
    task automatic read_check(input string req);
        rxq_entry_t e;
        if (sb_q.size() == 0) begin
            check({req, " scoreboard"}, 0, 1);
            return;
        end
        e = sb_q.pop_front();
        check({req, " avail"}, data_avail, 1);
        check({req, " data"}, rd_data, e.data);
        check({req, " bit9"}, rd_bit9, e.bit9);
        check({req, " frm_err"}, rd_frm_err, e.frm_err);
        check({req, " par_err"}, rd_par_err, e.par_err);
        check({req, " ovr"}, rd_ovr, e.ovr);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_en = 1'b1; irq_en = 1'b0; wr_valid = 1'b0; wr_data = '0;
        wr_bit9 = 1'b0; wr_frm_err = 1'b0; wr_par_err = 1'b0; start_det = 1'b0; rd_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R10 reset state
        check("R1 avail", data_avail, 0);
        check("R1 irq", irq, 0);
        check("R10 data", rd_data, 0);

        // R2 single frame, flags kept
        send(8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 1);
        check("R2 avail", data_avail, 1);
        read_check("R2");
        check("R10 empty after read", rd_data, 0);

        // R4 pop on empty, then a frame must still be intact
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        check("R4 empty pop", data_avail, 0);
        send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1);
        read_check("R4 after empty pop");
        check("R4 drained", data_avail, 0);

        // R3 / R5 three frames, pop with frame waiting
        send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        send(8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1);
        send(8'h33, 1'b0, 1'b1, 1'b1, 1'b0, 1);
        read_check("R5 first");
        check("R5 still full", data_avail, 1);
        read_check("R3 second");
        read_check("R3 third");
        check("R3 drained", data_avail, 0);

        // R11 start bit with full FIFO but empty hold: harmless
        send(8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        send(8'h42, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        pulse_start();
        send(8'h43, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        read_check("R11 a");
        read_check("R11 b");
        read_check("R11 c");

        // R6 / R7 overrun
        send(8'h51, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        send(8'h52, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        send(8'h53, 1'b0, 1'b0, 1'b0, 1'b0, 0);   // lost to overrun
        pulse_start();
        send(8'h54, 1'b1, 1'b0, 1'b0, 1'b1, 1);
        read_check("R6 pre");
        read_check("R6 before mark");
        read_check("R6 marked frame");
        send(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        read_check("R7 mark cleared");

        // R9 irq
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 no data no irq", irq, 0);
        send(8'h61, 1'b0, 1'b1, 1'b1, 1'b0, 1);
        send(8'h62, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        check("R9 irq high", irq, 1);
        read_check("R9 one");
        check("R9 irq stays", irq, 1);
        read_check("R9 two");
        check("R9 irq drops", irq, 0);
        irq_en = 1'b0;
        send(8'h63, 1'b0, 1'b1, 1'b1, 1'b0, 1);
        check("R9 errors raise no irq", irq, 0);
        read_check("R9 three");

        // R8 flush on disable
        send(8'h71, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        send(8'h72, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        send(8'h73, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        check("R8 flushed", data_avail, 0);
        send(8'h74, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        check("R8 write ignored", data_avail, 0);
        rx_en = 1'b1;
        @(negedge clk);
        check("R8 held frame lost", data_avail, 0);
        send(8'h75, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        read_check("R8 after enable");
        check("R8 drained", data_avail, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule